// File: doc/BRIEF.md
# Carry-Tracking Integer ALU

This block is the execute-stage arithmetic and logic unit of a small 32-bit controller core. Each cycle it takes a first source value, a second operand and an opcode, and produces a result and the next carry value combinationally. The second operand is either the second source register or an 8-bit immediate zero-extended to the data width. A one-bit immediate-select input chooses between them.

A single carry flag is held in a register inside the block. The flag feeds the carry-consuming opcodes and is reloaded only by the six arithmetic opcodes. All other opcodes leave it alone, so a multi-word add or subtract can be split across several cycles with logic work in between. For every subtraction form the flag carries the borrow.

Top module: `carryAlu`

## Requirements
- R1: The second operand is `{24'b0, immVal}` when `immSel` is 1, and `rs2Val` when `immSel` is 0.
- R2: Opcode 0 gives rs1+op2 and opcode 1 gives rs1+op2+flag. In both cases `carryOut` is bit 32 of the 33-bit sum and `result` is its low 32 bits.
- R3: Opcode 2 gives rs1−op2 and opcode 3 gives rs1−op2−flag. `carryOut` is bit 32 of the wide difference, so it is 1 exactly when a borrow occurs.
- R4: Opcode 4 gives op2−rs1 and opcode 5 gives op2−rs1−flag. `carryOut` is the borrow in the same way as R3.
- R5: Opcode 6 shifts rs1 left and opcode 7 shifts it right logically, with zero fill. The shift amount is op2[4:0].
- R6: Opcodes 8, 9 and 10 give rs1 AND, OR and XOR op2. Opcode 11 gives ~rs1 and takes no part of op2.
- R7: Opcode 12 gives the unsigned minimum of rs1 and op2. Opcode 13 gives the unsigned maximum.
- R8: Opcode 14 clears bit op2[4:0] of rs1. Opcode 15 sets that bit.
- R9: At each rising clock edge, `carryFlag` takes `carryOut` when the opcode is 0..5. For every other opcode it keeps its value, and `carryOut` then equals `carryFlag`.
- R10: While `rstN` is low, `carryFlag` is 0.
- R11: Opcodes 16..31 give a result of 0 and leave the flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opcode | input | 5 | Operation select |
| immSel | input | 1 | 1 selects the immediate as second operand |
| rs1Val | input | 32 | First source value |
| rs2Val | input | 32 | Second source register value |
| immVal | input | 8 | Immediate operand |
| result | output | 32 | Operation result |
| carryOut | output | 1 | Next carry value for this operation |
| carryFlag | output | 1 | Registered carry flag |

## Verification
The carry flag is the only state in the block. A wrong flag value has no effect until an opcode that consumes the flag runs. At that point it changes `result` by one, and it is also visible directly on `carryFlag` one edge after the arithmetic operation that loaded it. The bench checks the flag after every operation, so a wrong load or a lost hold is caught at the next edge instead of in a later carry-chained result. Random operand mixes run alongside directed borrow, wrap and shift-mask corners.

// File: rtl/carryAluPkg.sv
package carryAluPkg;

  localparam int OP_ADD  = 0;
  localparam int OP_ADC  = 1;
  localparam int OP_SUB  = 2;
  localparam int OP_SBC  = 3;
  localparam int OP_RSB  = 4;
  localparam int OP_RSC  = 5;
  localparam int OP_SHL  = 6;
  localparam int OP_SHR  = 7;
  localparam int OP_AND  = 8;
  localparam int OP_OR   = 9;
  localparam int OP_XOR  = 10;
  localparam int OP_NOT  = 11;
  localparam int OP_MIN  = 12;
  localparam int OP_MAX  = 13;
  localparam int OP_BCLR = 14;
  localparam int OP_BSET = 15;

  typedef enum logic [3:0] {
    SEL_ZERO, SEL_ARITH, SEL_SHL, SEL_SHR, SEL_AND, SEL_OR, SEL_XOR,
    SEL_NOT, SEL_MIN, SEL_MAX, SEL_BCLR, SEL_BSET
  } resSel_e;

  typedef struct packed {
    logic    arith;     // opcode reloads the carry flag
    logic    useCarry;  // flag enters the adder
    logic    subtract;  // adder subtracts
    logic    swap;      // op2 is the minuend
    resSel_e sel;
  } aluStrobes_t;

endpackage

// File: rtl/aluCtrl.sv
module aluCtrl
  import carryAluPkg::*;
#(
  parameter int OpW = 5
) (
  input  logic [OpW-1:0] opcode,
  output aluStrobes_t    strobes
);

  always_comb begin
    strobes = '{arith: 1'b0, useCarry: 1'b0, subtract: 1'b0, swap: 1'b0, sel: SEL_ZERO};
    case (opcode)
      OpW'(OP_ADD):  begin strobes.arith = 1'b1; strobes.sel = SEL_ARITH; end
      OpW'(OP_ADC):  begin strobes.arith = 1'b1; strobes.useCarry = 1'b1; strobes.sel = SEL_ARITH; end
      OpW'(OP_SUB):  begin strobes.arith = 1'b1; strobes.subtract = 1'b1; strobes.sel = SEL_ARITH; end
      OpW'(OP_SBC):  begin
        strobes.arith = 1'b1; strobes.subtract = 1'b1; strobes.useCarry = 1'b1; strobes.sel = SEL_ARITH;
      end
      OpW'(OP_RSB):  begin
        strobes.arith = 1'b1; strobes.subtract = 1'b1; strobes.swap = 1'b1; strobes.sel = SEL_ARITH;
      end
      OpW'(OP_RSC):  begin
        strobes.arith = 1'b1; strobes.subtract = 1'b1; strobes.swap = 1'b1;
        strobes.useCarry = 1'b1; strobes.sel = SEL_ARITH;
      end
      OpW'(OP_SHL):  strobes.sel = SEL_SHL;
      OpW'(OP_SHR):  strobes.sel = SEL_SHR;
      OpW'(OP_AND):  strobes.sel = SEL_AND;
      OpW'(OP_OR):   strobes.sel = SEL_OR;
      OpW'(OP_XOR):  strobes.sel = SEL_XOR;
      OpW'(OP_NOT):  strobes.sel = SEL_NOT;
      OpW'(OP_MIN):  strobes.sel = SEL_MIN;
      OpW'(OP_MAX):  strobes.sel = SEL_MAX;
      OpW'(OP_BCLR): strobes.sel = SEL_BCLR;
      OpW'(OP_BSET): strobes.sel = SEL_BSET;
      default:       strobes.sel = SEL_ZERO;
    endcase
  end

endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import carryAluPkg::*;
#(
  parameter int DataW = 32,
  parameter int ImmW  = 8
) (
  input  aluStrobes_t      strobes,
  input  logic             immSel,
  input  logic [DataW-1:0] rs1Val,
  input  logic [DataW-1:0] rs2Val,
  input  logic [ImmW-1:0]  immVal,
  input  logic             carryIn,
  output logic [DataW-1:0] result,
  output logic             carryNext
);

  localparam int ShW = $clog2(DataW);

  logic [DataW-1:0] op2;
  logic [DataW-1:0] lhs;
  logic [DataW-1:0] rhs;
  logic [DataW:0]   sumWide;
  logic [DataW:0]   cinWide;
  logic [ShW-1:0]   bitIdx;
  logic [DataW-1:0] bitMask;

  assign op2     = immSel ? {{(DataW-ImmW){1'b0}}, immVal} : rs2Val;
  assign lhs     = strobes.swap ? op2 : rs1Val;
  assign rhs     = strobes.swap ? rs1Val : op2;
  assign cinWide = {{DataW{1'b0}}, strobes.useCarry & carryIn};
  assign bitIdx  = op2[ShW-1:0];
  assign bitMask = {{(DataW-1){1'b0}}, 1'b1} << bitIdx;

  always_comb begin
    if (strobes.subtract) sumWide = {1'b0, lhs} - {1'b0, rhs} - cinWide;
    else                  sumWide = {1'b0, lhs} + {1'b0, rhs} + cinWide;
  end

  always_comb begin
    case (strobes.sel)
      SEL_ARITH: result = sumWide[DataW-1:0];
      SEL_SHL:   result = rs1Val << bitIdx;
      SEL_SHR:   result = rs1Val >> bitIdx;
      SEL_AND:   result = rs1Val & op2;
      SEL_OR:    result = rs1Val | op2;
      SEL_XOR:   result = rs1Val ^ op2;
      SEL_NOT:   result = ~rs1Val;
      SEL_MIN:   result = (rs1Val < op2) ? rs1Val : op2;
      SEL_MAX:   result = (rs1Val > op2) ? rs1Val : op2;
      SEL_BCLR:  result = rs1Val & ~bitMask;
      SEL_BSET:  result = rs1Val | bitMask;
      default:   result = '0;
    endcase
  end

  assign carryNext = strobes.arith ? sumWide[DataW] : carryIn;

endmodule

// File: rtl/carryAlu.sv
module carryAlu
  import carryAluPkg::*;
#(
  parameter int DataW = 32,
  parameter int ImmW  = 8,
  parameter int OpW   = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [OpW-1:0]   opcode,
  input  logic             immSel,
  input  logic [DataW-1:0] rs1Val,
  input  logic [DataW-1:0] rs2Val,
  input  logic [ImmW-1:0]  immVal,
  output logic [DataW-1:0] result,
  output logic             carryOut,
  output logic             carryFlag
);

  aluStrobes_t strobes;

  aluCtrl #(.OpW(OpW)) u_ctrl (
    .opcode  (opcode),
    .strobes (strobes)
  );

  aluDatapath #(.DataW(DataW), .ImmW(ImmW)) u_dp (
    .strobes   (strobes),
    .immSel    (immSel),
    .rs1Val    (rs1Val),
    .rs2Val    (rs2Val),
    .immVal    (immVal),
    .carryIn   (carryFlag),
    .result    (result),
    .carryNext (carryOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) carryFlag <= 1'b0;
    else       carryFlag <= carryOut;
  end

endmodule

// File: rtl/carryAluChecker.sv
module carryAluChecker #(
  parameter int DataW = 32,
  parameter int ImmW  = 8,
  parameter int OpW   = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [OpW-1:0]   opcode,
  input logic             immSel,
  input logic [DataW-1:0] rs1Val,
  input logic [DataW-1:0] rs2Val,
  input logic [ImmW-1:0]  immVal,
  input logic [DataW-1:0] result,
  input logic             carryOut,
  input logic             carryFlag
);

  logic [DataW-1:0] op2View;
  logic             arithOp;
  assign op2View = immSel ? {{(DataW-ImmW){1'b0}}, immVal} : rs2Val;
  assign arithOp = opcode < OpW'(6);

  AST_CARRY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    arithOp |=> carryFlag == $past(carryOut)); // R9

  AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !arithOp |=> carryFlag == $past(carryFlag)); // R9

  AST_NOT_IGNORES_OP2: assert property (@(posedge clk) disable iff (!rstN)
    opcode == OpW'(11) |-> result == ~rs1Val); // R6

  AST_MIN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    opcode == OpW'(12) |-> (result <= rs1Val && result <= op2View)); // R7

  AST_MAX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    opcode == OpW'(13) |-> (result >= rs1Val && result >= op2View)); // R7

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    opcode >= OpW'(16) |-> (result == '0 && carryOut == carryFlag)); // R11

endmodule

bind carryAlu carryAluChecker #(.DataW(DataW), .ImmW(ImmW), .OpW(OpW)) u_carryAluChecker (
  .clk(clk), .rstN(rstN), .opcode(opcode), .immSel(immSel), .rs1Val(rs1Val),
  .rs2Val(rs2Val), .immVal(immVal), .result(result), .carryOut(carryOut),
  .carryFlag(carryFlag)
);

// File: tb/carryAlu_bench.sv
module carryAlu_bench;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  opcode = '0;
  logic        immSel = 1'b0;
  logic [31:0] rs1Val = '0;
  logic [31:0] rs2Val = '0;
  logic [7:0]  immVal = '0;
  logic [31:0] result;
  logic        carryOut;
  logic        carryFlag;

  int checks = 0;
  int fails = 0;
  logic modelCarry = 1'b0;
  bit   finished = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  carryAlu u_carryAlu (
    .clk(clk), .rstN(rstN), .opcode(opcode), .immSel(immSel), .rs1Val(rs1Val),
    .rs2Val(rs2Val), .immVal(immVal), .result(result), .carryOut(carryOut),
    .carryFlag(carryFlag)
  );

  function automatic string reqOf(input logic [4:0] op);
    if (op <= 1) return "R2";
    if (op <= 3) return "R3";
    if (op <= 5) return "R4";
    if (op <= 7) return "R5";
    if (op <= 11) return "R6";
    if (op <= 13) return "R7";
    if (op <= 15) return "R8";
    return "R11";
  endfunction

  function automatic logic [32:0] model(input logic [4:0] op, input logic [31:0] a,
                                        input logic [31:0] b, input logic c);
    logic [63:0] w;
    logic [31:0] m;
    m = 32'd1 << b[4:0];
    case (op)
      5'd0:  begin w = {32'b0, a} + {32'b0, b};            return {w[32], w[31:0]}; end
      5'd1:  begin w = {32'b0, a} + {32'b0, b} + {63'b0, c}; return {w[32], w[31:0]}; end
      5'd2:  begin w = {32'b0, a} - {32'b0, b};            return {w[32], w[31:0]}; end
      5'd3:  begin w = {32'b0, a} - {32'b0, b} - {63'b0, c}; return {w[32], w[31:0]}; end
      5'd4:  begin w = {32'b0, b} - {32'b0, a};            return {w[32], w[31:0]}; end
      5'd5:  begin w = {32'b0, b} - {32'b0, a} - {63'b0, c}; return {w[32], w[31:0]}; end
      5'd6:  return {c, a << b[4:0]};
      5'd7:  return {c, a >> b[4:0]};
      5'd8:  return {c, a & b};
      5'd9:  return {c, a | b};
      5'd10: return {c, a ^ b};
      5'd11: return {c, ~a};
      5'd12: return {c, (a < b) ? a : b};
      5'd13: return {c, (a > b) ? a : b};
      5'd14: return {c, a & ~m};
      5'd15: return {c, a | m};
      default: return {c, 32'd0};
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic doOp(input logic [4:0] op, input logic sel, input logic [31:0] a,
                      input logic [31:0] r2, input logic [7:0] imm, input string req);
    logic [32:0] exp;
    logic [31:0] b;
    @(negedge clk);
    opcode = op; immSel = sel; rs1Val = a; rs2Val = r2; immVal = imm;
    b = sel ? {24'b0, imm} : r2;
    exp = model(op, a, b, modelCarry);
    #1;
    check(req, "result", result, exp[31:0]);
    check(req, "carryOut", {31'b0, carryOut}, {31'b0, exp[32]});
    @(posedge clk);
    #1;
    modelCarry = exp[32];
    check((op < 6) ? req : "R9", "carryFlag", {31'b0, carryFlag}, {31'b0, modelCarry});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    #1;
    check("R10", "carryFlag in reset", {31'b0, carryFlag}, 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    doOp(5'd0, 0, 32'hFFFF_FFFF, 32'd1, 8'h00, "R2");   // wrap, carry 1
    doOp(5'd8, 0, 32'h1234_5678, 32'h0, 8'h00, "R9");   // flag holds at 1
    doOp(5'd1, 0, 32'd0, 32'd0, 8'h00, "R2");           // 0+0+1
    doOp(5'd2, 0, 32'd0, 32'd1, 8'h00, "R3");           // borrow
    doOp(5'd3, 0, 32'd5, 32'd3, 8'h00, "R3");           // 5-3-1
    doOp(5'd4, 1, 32'h20, 32'hDEAD_BEEF, 8'h10, "R1");  // imm path: 0x10-0x20
    doOp(5'd5, 0, 32'd1, 32'd9, 8'h00, "R4");           // 9-1-1
    doOp(5'd6, 1, 32'h8000_0001, 32'd0, 8'd33, "R5");   // amount masked to 1
    doOp(5'd7, 0, 32'h8000_0000, 32'd31, 8'h00, "R5");  // logical fill
    doOp(5'd11, 1, 32'h0F0F_0000, 32'd0, 8'hFF, "R6");
    doOp(5'd12, 0, 32'hFFFF_FFFF, 32'd1, 8'h00, "R7");  // unsigned compare
    doOp(5'd13, 0, 32'hFFFF_FFFF, 32'd1, 8'h00, "R7");
    doOp(5'd15, 1, 32'd0, 32'd0, 8'd37, "R8");          // index masked to 5
    doOp(5'd14, 0, 32'hFFFF_FFFF, 32'd63, 8'h00, "R8");
    doOp(5'd0, 0, 32'h8000_0000, 32'h8000_0000, 8'h0, "R2");
    doOp(5'd17, 0, 32'hAAAA_5555, 32'd3, 8'h00, "R11"); // flag stays 1
    doOp(5'd31, 1, 32'hFFFF_FFFF, 32'd0, 8'hFF, "R11");

    for (int i = 0; i < 600; i++) begin
      logic [4:0]  op;
      logic [31:0] a;
      logic [31:0] r2;
      op = 5'($urandom_range(0, 19));
      a  = ($urandom_range(0, 7) == 0) ? 32'hFFFF_FFFF : $urandom;
      r2 = ($urandom_range(0, 7) == 0) ? a : $urandom;
      doOp(op, 1'($urandom_range(0, 1)), a, r2, 8'($urandom), reqOf(op));
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule